// File: doc/BRIEF.md
# Byte-Wide Host Port for 24-Bit Words

This block is a slave port through which an external host with an 8-bit bus exchanges 24-bit words with an internal processor. The host picks one of its registers with a 3-bit address, sets the direction with a read/write line and frames each access with an active-low enable strobe. Each word moves as three bytes in a fixed order: high, middle, low. The access to the low byte completes the word. Status bits tell the host when a word is waiting and when the outgoing byte registers may be refilled. An active-low service-request pin tells the host when the port needs attention.

The host can also raise a command with a vector, and cancel it before the processor takes it. Two flag bits pass in each direction, and each bit has its own synchronizer. In DMA mode an acknowledge pin takes the place of the address decode, and an internal pointer steps through the three bytes. When the port is disabled, all 15 host pins become general-purpose I/O. Their directions come out of reset as inputs.

All host inputs pass through synchronizers into the processor clock. A host write is committed once, when the synchronized strobe is released.

Top module: `host_byte_port`

## Requirements
- R1: After reset with the port disabled, all 15 pins are inputs (pin_oe is 0). With the port enabled, pin 13 is an output and idles high (no request).
- R2: Host register addresses are 0 control, 1 status, 2 command, 5 high byte, 6 middle byte and 7 low byte. The data pins are driven with the selected register while enable (pin 12) is low and read/write (pin 11) is high. Status bit 0 is receive-full, bit 1 is transmit-empty, bits 3:2 are the processor flags and bit 4 is command-pending. Reset status reads 0x02.
- R3: Host writes to addresses 5 and 6 followed by a write to 7 deliver the word {high,middle,low} to cpu_rx_word with cpu_rx_valid set, and transmit-empty clears. A pulse on cpu_rx_take sets transmit-empty again.
- R4: A low-byte write while cpu_rx_valid is still set is ignored, and cpu_rx_word keeps its value.
- R5: cpu_tx_load fills the three receive bytes and sets receive-full, and a load while receive-full is set is ignored. Reading address 7 clears receive-full. Accesses to the high or middle byte never change any status bit.
- R6: Pin 13 goes low when receive-full is set and control bit 2 is set, or when transmit-empty is set and control bit 3 is set. It returns high after the low-byte access that removes the cause.
- R7: Writing address 2 sets command-pending from data bit 7 and the vector from bits 4:0, so writing bit 7 as 0 cancels the command. cmd_ack clears command-pending.
- R8: Control bits 1:0 reach hflag_cpu, and cflag_in reaches status bits 3:2. Each bit passes through its own synchronizer.
- R9: With dma_en set, the acknowledge pin (14, active low) strobes the bytes in the order high, middle, low, with no address decode. Pin 13 is held high while acknowledge is active.
- R10: With the port disabled, pin_oe and pin_out come from the direction and value registers loaded by gp_load, and gp_in follows pin_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| port_en | input | 1 | 1 selects host port mode, 0 selects general-purpose I/O |
| dma_en | input | 1 | Acknowledge-strobed byte transfers |
| pin_in | input | 15 | Pin levels: [7:0] data, [10:8] address, [11] read/write, [12] enable_n, [14] ack_n |
| pin_out | output | 15 | Pin output values; [13] is the request (active low) |
| pin_oe | output | 15 | Pin output enables |
| gp_in | output | 15 | Pin levels seen by the processor |
| gp_load | input | 1 | Load the I/O direction and value registers |
| gp_dir_d | input | 15 | New I/O directions (1 = output) |
| gp_out_d | input | 15 | New I/O output values |
| cpu_rx_word | output | 24 | Word assembled from host writes |
| cpu_rx_valid | output | 1 | cpu_rx_word holds an unread word |
| cpu_rx_take | input | 1 | Processor consumes cpu_rx_word |
| cpu_tx_word | input | 24 | Word offered to the host |
| cpu_tx_load | input | 1 | Load cpu_tx_word into the receive bytes |
| hflag_cpu | output | 2 | Synchronized host flags |
| cflag_in | input | 2 | Processor flags for the host |
| cmd_req | output | 1 | Host command pending |
| cmd_vec | output | 5 | Host command vector |
| cmd_ack | input | 1 | Processor recognized the command |

## Verification
A host access takes effect on the third rising clock after its enable or acknowledge is released: two synchronizer stages, then one register update. Each bench task therefore holds the strobe for four clocks and waits four more before it returns. Status reads are sampled two clocks into the strobe, because the data pins follow the raw address. Flag crossings add two clocks on top of the commit, and the bench waits six or more before it compares.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
   localparam int HADDR_W = 3;

   typedef enum logic [HADDR_W-1:0] {
      A_CTRL = 3'd0,
      A_STAT = 3'd1,
      A_CMD  = 3'd2,
      A_HI   = 3'd5,
      A_MID  = 3'd6,
      A_LO   = 3'd7
   } haddr_e;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbp_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= {STAGES{RST_VAL}};
         else        sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end
endmodule

// File: rtl/hbp_strobe.sv
module hbp_strobe #(
   parameter int INFO_W = 12,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic [INFO_W-1:0] info,
   output logic              act,
   output logic              done,
   output logic [INFO_W-1:0] held
);
   logic              sel_s;
   logic [INFO_W-1:0] info_s;
   logic              act_d;

   hbp_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) i_sel_sync (
      .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_s));
   hbp_sync #(.W(INFO_W), .STAGES(STAGES), .RST_VAL(1'b0)) i_info_sync (
      .clk(clk), .rst_n(rst_n), .d(info), .q(info_s));

   assign act  = ~sel_s;
   assign done = act_d & ~act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d <= 1'b0;
         held  <= '0;
      end else begin
         act_d <= act;
         if (act) held <= info_s;
      end
   end
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
   import hbp_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int NFLAG       = 2,
   parameter int VEC_W       = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         port_en,
   input  logic                         dma_en,
   input  logic [BYTE_W+HADDR_W+3:0]    pin_in,
   output logic [BYTE_W+HADDR_W+3:0]    pin_out,
   output logic [BYTE_W+HADDR_W+3:0]    pin_oe,
   output logic [BYTE_W+HADDR_W+3:0]    gp_in,
   input  logic                         gp_load,
   input  logic [BYTE_W+HADDR_W+3:0]    gp_dir_d,
   input  logic [BYTE_W+HADDR_W+3:0]    gp_out_d,
   output logic [3*BYTE_W-1:0]          cpu_rx_word,
   output logic                         cpu_rx_valid,
   input  logic                         cpu_rx_take,
   input  logic [3*BYTE_W-1:0]          cpu_tx_word,
   input  logic                         cpu_tx_load,
   output logic [NFLAG-1:0]             hflag_cpu,
   input  logic [NFLAG-1:0]             cflag_in,
   output logic                         cmd_req,
   output logic [VEC_W-1:0]             cmd_vec,
   input  logic                         cmd_ack
);
   localparam int BW     = BYTE_W;
   localparam int WW     = 3 * BW;
   localparam int PINS   = BW + HADDR_W + 4;
   localparam int P_RW   = BW + HADDR_W;
   localparam int P_EN   = P_RW + 1;
   localparam int P_REQ  = P_EN + 1;
   localparam int P_ACK  = P_REQ + 1;
   localparam int INFO_W = BW + HADDR_W + 1;
   localparam int CTRL_W = NFLAG + 2;

   if (NFLAG + 3 > BW) begin : g_bad_flags
      $error("host_byte_port: status byte cannot hold the flags");
   end
   if (VEC_W >= BW) begin : g_bad_vec
      $error("host_byte_port: vector overlaps the command bit");
   end

   // host strobe capture
   logic              s_act, s_done;
   logic [INFO_W-1:0] s_held;
   logic              s_rw;
   logic [HADDR_W-1:0] s_addr;
   logic [BW-1:0]     s_data;
   logic              sel_n;

   assign sel_n = dma_en ? pin_in[P_ACK] : pin_in[P_EN];

   hbp_strobe #(.INFO_W(INFO_W), .STAGES(SYNC_STAGES)) i_strobe (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
      .info(pin_in[P_RW:0]), .act(s_act), .done(s_done), .held(s_held));

   assign s_rw   = s_held[INFO_W-1];
   assign s_addr = s_held[BW+HADDR_W-1:BW];
   assign s_data = s_held[BW-1:0];

   // state
   logic [1:0]         dptr;
   logic [HADDR_W-1:0] eff_addr, raw_addr;
   logic               wr_go, rd_go;
   logic [BW-1:0]      tx_hi, tx_mid;
   logic [WW-1:0]      rx_word;
   logic               rx_full, tx_empty;
   logic [CTRL_W-1:0]  ctrl;
   logic [NFLAG-1:0]   cflag_s;
   logic [PINS-1:0]    gp_dir, gp_val;

   assign eff_addr = dma_en ? HADDR_W'(A_HI) + HADDR_W'(dptr) : s_addr;
   assign raw_addr = dma_en ? HADDR_W'(A_HI) + HADDR_W'(dptr) : pin_in[P_RW-1:BW];
   assign wr_go    = port_en & s_done & ~s_rw;
   assign rd_go    = port_en & s_done & s_rw;
   assign tx_empty = ~cpu_rx_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dptr         <= '0;
         tx_hi        <= '0;
         tx_mid       <= '0;
         cpu_rx_word  <= '0;
         cpu_rx_valid <= 1'b0;
         rx_word      <= '0;
         rx_full      <= 1'b0;
         ctrl         <= '0;
         cmd_req      <= 1'b0;
         cmd_vec      <= '0;
      end else begin
         if (!dma_en)                  dptr <= '0;
         else if (port_en && s_done)   dptr <= (dptr == 2'd2) ? 2'd0 : dptr + 2'd1;

         if (cpu_rx_take) cpu_rx_valid <= 1'b0;
         if (cpu_tx_load && !rx_full) begin
            rx_word <= cpu_tx_word;
            rx_full <= 1'b1;
         end

         if (wr_go) begin
            unique case (eff_addr)
               A_HI:  tx_hi  <= s_data;
               A_MID: tx_mid <= s_data;
               A_LO: if (!cpu_rx_valid) begin
                  cpu_rx_word  <= {tx_hi, tx_mid, s_data};
                  cpu_rx_valid <= 1'b1;
               end
               A_CTRL: if (!dma_en) ctrl <= s_data[CTRL_W-1:0];
               A_CMD: if (!dma_en) begin
                  cmd_req <= s_data[BW-1];
                  cmd_vec <= s_data[VEC_W-1:0];
               end
               default: ;
            endcase
         end
         if (rd_go && eff_addr == HADDR_W'(A_LO)) rx_full <= 1'b0;
         if (cmd_ack) cmd_req <= 1'b0;
      end
   end

   // flag crossings, one synchronizer per bit
   hbp_sync #(.W(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_hflag_sync (
      .clk(clk), .rst_n(rst_n), .d(ctrl[NFLAG-1:0]), .q(hflag_cpu));
   hbp_sync #(.W(NFLAG), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_cflag_sync (
      .clk(clk), .rst_n(rst_n), .d(cflag_in), .q(cflag_s));

   // general-purpose I/O registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gp_dir <= '0;
         gp_val <= '0;
      end else if (gp_load) begin
         gp_dir <= gp_dir_d;
         gp_val <= gp_out_d;
      end
   end
   assign gp_in = pin_in;

   // host read path
   logic [BW-1:0] rd_val;
   logic          drive, req;

   always_comb begin
      rd_val = '0;
      unique case (raw_addr)
         A_CTRL: rd_val[CTRL_W-1:0] = ctrl;
         A_STAT: begin
            rd_val[0]           = rx_full;
            rd_val[1]           = tx_empty;
            rd_val[NFLAG+1:2]   = cflag_s;
            rd_val[NFLAG+2]     = cmd_req;
         end
         A_CMD: begin
            rd_val[BW-1]        = cmd_req;
            rd_val[VEC_W-1:0]   = cmd_vec;
         end
         A_HI:  rd_val = rx_word[WW-1:2*BW];
         A_MID: rd_val = rx_word[2*BW-1:BW];
         A_LO:  rd_val = rx_word[BW-1:0];
         default: rd_val = '0;
      endcase
   end

   assign drive = pin_in[P_RW] & ~(dma_en ? pin_in[P_ACK] : pin_in[P_EN]);
   assign req   = (rx_full & ctrl[NFLAG]) | (tx_empty & ctrl[NFLAG+1]);

   always_comb begin
      if (port_en) begin
         pin_oe          = '0;
         pin_out         = '0;
         pin_oe[BW-1:0]  = {BW{drive}};
         pin_out[BW-1:0] = rd_val;
         pin_oe[P_REQ]   = 1'b1;
         pin_out[P_REQ]  = ~(req & ~(dma_en & s_act));
      end else begin
         pin_oe  = gp_dir;
         pin_out = gp_val;
      end
   end
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
   parameter int BW = 8,
   parameter int WW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          port_en,
   input logic          s_done,
   input logic          s_rw,
   input logic [2:0]    eff_addr,
   input logic [BW-1:0] s_data,
   input logic          cpu_rx_valid,
   input logic [WW-1:0] cpu_rx_word,
   input logic          cpu_rx_take,
   input logic          rx_full,
   input logic          cmd_ack,
   input logic          cmd_req
);
   // R3: a low-byte write into an empty slot delivers a word
   assert_word_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && s_done && !s_rw && eff_addr == 3'd7 && !cpu_rx_valid)
      |=> (cpu_rx_valid && cpu_rx_word[BW-1:0] == $past(s_data)));

   // R4: an unconsumed word is never overwritten
   assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rx_valid && !cpu_rx_take) |=> (cpu_rx_valid && $stable(cpu_rx_word)));

   // R5: receive-full only drops through a low-byte read
   assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !(port_en && s_done && s_rw && eff_addr == 3'd7)) |=> rx_full);

   // R7: acknowledge retires the command
   assert_cmd_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ack |=> !cmd_req);
endmodule

bind host_byte_port hbp_checker #(.BW(BW), .WW(WW)) i_hbp_checker (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .s_done(s_done), .s_rw(s_rw),
   .eff_addr(eff_addr), .s_data(s_data), .cpu_rx_valid(cpu_rx_valid),
   .cpu_rx_word(cpu_rx_word), .cpu_rx_take(cpu_rx_take), .rx_full(rx_full),
   .cmd_ack(cmd_ack), .cmd_req(cmd_req));

// File: tb/test_host_byte_port.sv
module test_host_byte_port;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;
   // {op(1=read), addr(3), data(8), expected(8)}
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b0, 3'd5, 8'h12, 8'h00},
      {1'b0, 3'd6, 8'h34, 8'h00},
      {1'b1, 3'd1, 8'h00, 8'h02},
      {1'b1, 3'd5, 8'h00, 8'h00},
      {1'b0, 3'd7, 8'h56, 8'h00},
      {1'b1, 3'd1, 8'h00, 8'h00},
      {1'b0, 3'd2, 8'h85, 8'h00},
      {1'b1, 3'd1, 8'h00, 8'h10},
      {1'b1, 3'd2, 8'h00, 8'h85},
      {1'b0, 3'd2, 8'h05, 8'h00},
      {1'b1, 3'd1, 8'h00, 8'h00},
      {1'b0, 3'd0, 8'h03, 8'h00},
      {1'b1, 3'd0, 8'h00, 8'h03}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0, dma_en = 1'b0;
   logic [14:0] pin_in = 15'h5000;
   logic [14:0] pin_out, pin_oe, gp_in;
   logic        gp_load = 1'b0;
   logic [14:0] gp_dir_d = '0, gp_out_d = '0;
   logic [23:0] cpu_rx_word;
   logic        cpu_rx_valid;
   logic        cpu_rx_take = 1'b0;
   logic [23:0] cpu_tx_word = '0;
   logic        cpu_tx_load = 1'b0;
   logic [1:0]  hflag_cpu;
   logic [1:0]  cflag_in = '0;
   logic        cmd_req;
   logic [4:0]  cmd_vec;
   logic        cmd_ack = 1'b0;

   int checks = 0, errors = 0;
   logic [7:0] rv;

   always #(CLK_PERIOD/2) clk = ~clk;

   host_byte_port i_host_byte_port (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .dma_en(dma_en),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .gp_in(gp_in),
      .gp_load(gp_load), .gp_dir_d(gp_dir_d), .gp_out_d(gp_out_d),
      .cpu_rx_word(cpu_rx_word), .cpu_rx_valid(cpu_rx_valid), .cpu_rx_take(cpu_rx_take),
      .cpu_tx_word(cpu_tx_word), .cpu_tx_load(cpu_tx_load),
      .hflag_cpu(hflag_cpu), .cflag_in(cflag_in),
      .cmd_req(cmd_req), .cmd_vec(cmd_vec), .cmd_ack(cmd_ack));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [2:0] a, input logic [7:0] d);
      pin_in[10:8] = a; pin_in[11] = 1'b0; pin_in[7:0] = d; pin_in[12] = 1'b0;
      wait_n(4);
      pin_in[12] = 1'b1;
      wait_n(4);
   endtask

   task automatic host_read(input logic [2:0] a, output logic [7:0] d);
      pin_in[10:8] = a; pin_in[11] = 1'b1; pin_in[12] = 1'b0;
      wait_n(2);
      d = pin_out[7:0];
      wait_n(2);
      pin_in[12] = 1'b1;
      wait_n(4);
   endtask

   task automatic dma_write(input logic [7:0] d);
      pin_in[11] = 1'b0; pin_in[7:0] = d; pin_in[14] = 1'b0;
      wait_n(4);
      pin_in[14] = 1'b1;
      wait_n(4);
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; wait_n(1); s = 1'b0; wait_n(1);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      check("R1 pins inputs after reset", pin_oe, 15'h0000);
      port_en = 1'b1;
      wait_n(1);
      check("R1 request pin driven", pin_oe[13], 1'b1);
      check("R1 request idle high", pin_out[13], 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][19]) begin
            host_read(VEC[i][18:16], rv);
            check($sformatf("R2 R5 R7 table row %0d", i), rv, VEC[i][7:0]);
         end else begin
            host_write(VEC[i][18:16], VEC[i][15:8]);
         end
      end

      check("R3 word delivered", cpu_rx_word, 24'h123456);
      check("R3 word valid", cpu_rx_valid, 1'b1);
      check("R8 host flags crossed", hflag_cpu, 2'b11);
      check("R7 command cancelled", cmd_req, 1'b0);

      // R4: low byte while word unconsumed
      host_write(3'd5, 8'hAA);
      host_write(3'd7, 8'hBB);
      check("R4 overrun ignored", cpu_rx_word, 24'h123456);
      pulse(cpu_rx_take);
      host_read(3'd1, rv);
      check("R3 take sets transmit-empty", rv, 8'h02);

      // R5 / R6 receive direction with request
      host_write(3'd0, 8'h04);
      cpu_tx_word = 24'hABCDEF;
      pulse(cpu_tx_load);
      check("R6 request on receive-full", pin_out[13], 1'b0);
      cpu_tx_word = 24'h111111;
      pulse(cpu_tx_load);
      host_read(3'd5, rv);
      check("R5 high byte", rv, 8'hAB);
      host_read(3'd6, rv);
      check("R5 middle byte, load while full ignored", rv, 8'hCD);
      host_read(3'd1, rv);
      check("R5 middle read keeps full", rv, 8'h03);
      host_read(3'd7, rv);
      check("R5 low byte", rv, 8'hEF);
      host_read(3'd1, rv);
      check("R5 low read clears full", rv, 8'h02);
      check("R6 request dropped", pin_out[13], 1'b1);

      // R8 processor flags
      cflag_in = 2'b10;
      wait_n(4);
      host_read(3'd1, rv);
      check("R8 processor flags crossed", rv[3:2], 2'b10);
      cflag_in = 2'b00;

      // R7 command and acknowledge
      host_write(3'd2, 8'h93);
      check("R7 command raised", cmd_req, 1'b1);
      check("R7 vector", cmd_vec, 5'h13);
      pulse(cmd_ack);
      check("R7 acknowledge clears", cmd_req, 1'b0);

      // R9 DMA
      host_write(3'd0, 8'h08);
      dma_en = 1'b1;
      wait_n(1);
      check("R6 R9 request on transmit-empty", pin_out[13], 1'b0);
      pin_in[11] = 1'b0; pin_in[7:0] = 8'h01; pin_in[14] = 1'b0;
      wait_n(3);
      check("R9 request held off during acknowledge", pin_out[13], 1'b1);
      wait_n(1);
      pin_in[14] = 1'b1;
      wait_n(4);
      dma_write(8'h02);
      dma_write(8'h03);
      check("R9 DMA word order", cpu_rx_word, 24'h010203);
      check("R9 DMA word valid", cpu_rx_valid, 1'b1);
      dma_en = 1'b0;
      pulse(cpu_rx_take);

      // R10 general-purpose I/O
      port_en = 1'b0;
      gp_dir_d = 15'h00FF; gp_out_d = 15'h00A5;
      pulse(gp_load);
      check("R10 directions", pin_oe, 15'h00FF);
      check("R10 values", pin_out, 15'h00A5);
      pin_in = 15'h2C3D;
      wait_n(1);
      check("R10 input levels", gp_in, 15'h2C3D);

      finish_run();
   end
endmodule